// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves translation misses from a TLB by reading a four-level radix page table held in memory. A miss request carries a 48-bit virtual address and a read/write flag. The walker starts at the root table frame, reads one 64-bit entry per level, and follows each entry to the next table until it reaches a leaf or an entry that is not present. It returns either a physical address with a page-size code, or a fault.

A small fully associative cache holds pointers to lowest-level tables, tagged by virtual address bits 47:21. When a request hits in this cache, the walk needs one memory read instead of four. Directory entries with the large-page flag end the walk early, giving 2 MiB or 1 GiB pages. When the walker uses a leaf, it writes the entry back with its accessed flag set, and also its dirty flag on a write access. It writes back only when this changes a flag. A flush input empties the directory cache in one cycle.

Levels are numbered 3 (root, VA 47:39), 2 (VA 38:30), 1 (VA 29:21) and 0 (VA 20:12). Entry fields: bit 0 present, bit 5 accessed, bit 6 dirty, bit 7 large page, bits PA_W-1:12 the frame. Entry addresses are {table frame, 9-bit index, 3'b000}.

Top module: `pt_walker`

## Requirements
- R1: With an empty directory cache, a walk reads the entries at levels 3, 2, 1 and 0 in that order, starting from `rootFrame`. Each read uses the frame found at the level above. A level-0 leaf gives {frame, VA[11:0]} with size code 0.
- R2: When VA[47:21] hits in the directory cache, the walk makes exactly one memory read, at level 0.
- R3: A present level-1 entry with bit 7 set is a 2 MiB leaf: {entry[PA_W-1:21], VA[20:0]}, size code 1, after three reads. A present level-2 entry with bit 7 set is a 1 GiB leaf: {entry[PA_W-1:30], VA[29:0]}, size code 2, after two reads. Bit 7 is ignored at levels 3 and 0.
- R4: An entry with bit 0 clear ends the walk. The response has `rspFault`=1 and `rspSize` equal to the level of that entry, and no further read or any write follows.
- R5: When a leaf has bit 5 clear, the walker writes the entry back to the same address with bit 5 set before it responds. When the leaf already carries every flag that the access needs, no write occurs.
- R6: On a write access to a leaf with bit 6 clear, the written-back entry also has bit 6 set.
- R7: Each present, non-large level-1 entry is inserted into an 8-entry directory cache with round-robin replacement. The ninth distinct insertion evicts the oldest entry.
- R8: A `flush` pulse empties the directory cache by the next cycle. A walk already in progress finishes with the entries it fetched and may still insert into the cache after the flush.
- R9: Only one walk is in flight. `reqReady` stays low from the moment a request is accepted until its response is accepted. While `rspReady` is low, the response holds steady and no memory request is issued.
- R10: A memory request holds its address, write flag and data until `memReady` is high. Read data arrives later on `memRdValid`.
- R11: After reset, `reqReady`=1, `rspValid`=0 and `memValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the directory cache |
| rootFrame | input | PA_W-12 | Frame of the root table |
| reqValid | input | 1 | Miss request valid |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 48 | Virtual address to translate |
| reqWrite | input | 1 | Access is a write |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Requester takes the response |
| rspFault | output | 1 | Walk hit a non-present entry |
| rspSize | output | 2 | Level of leaf or faulting entry |
| rspPaddr | output | PA_W | Physical address (when no fault) |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | PA_W | Entry address |
| memWdata | output | 64 | Entry written back |
| memRdValid | input | 1 | Read data valid |
| memRdata | input | 64 | Read entry |

## Verification
The bench counts memory reads per walk, which shows whether a cache hit skipped three levels. A walker that ignored the cache would read four times, and one that trusted a stale or evicted slot would read only once. Large-page leaves at levels 1 and 2 are checked both for the address splice and for the read count, so a walker that descended past a large leaf would read too often. The tests cover flag write-back once, twice (dirty added) and not at all, a flush while idle and a flush in the middle of a walk, round-robin eviction after nine fills, and faults at three different levels. The response is held with `rspReady` low while a second request waits, which catches a walker that accepts early or drops its result.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W      = 48;
  localparam int PTE_W     = 64;
  localparam int IDX_W     = 9;
  localparam int OFS_W     = 12;
  localparam int PDE_SHIFT = OFS_W + IDX_W;   // 21
  localparam int GIG_SHIFT = PDE_SHIFT + IDX_W; // 30

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_ACCESSED = 5;
  localparam int BIT_DIRTY    = 6;
  localparam int BIT_LARGE    = 7;

  typedef struct packed {
    logic acceptReq;   // latch request, pick start level
    logic latchEntry;  // capture returned entry
    logic stepDown;    // follow entry to next table
    logic pscFill;     // insert level-1 pointer in directory cache
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_DECIDE, ST_WR_REQ, ST_RESP
  } walkState_t;
endpackage

// File: rtl/pt_walker_psc.sv
module pt_walker_psc #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 27,
  parameter int DATA_W  = 28
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic [TAG_W-1:0]   lookupTag,
  output logic               hit,
  output logic [DATA_W-1:0]  hitData,
  input  logic               fillEn,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [DATA_W-1:0]  fillData,
  output logic [ENTRIES-1:0] validVec
);
  localparam int PTR_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagQ  [ENTRIES];
  logic [DATA_W-1:0]  dataQ [ENTRIES];
  logic [PTR_W-1:0]   ptrQ;
  logic [ENTRIES-1:0] matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      ptrQ   <= '0;
    end else if (flush) begin
      validQ <= '0;
    end else if (fillEn) begin
      validQ[ptrQ] <= 1'b1;
      ptrQ <= (ptrQ == PTR_W'(ENTRIES-1)) ? '0 : ptrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && !flush) begin
      tagQ[ptrQ]  <= fillTag;
      dataQ[ptrQ] <= fillData;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign matchVec[g] = validQ[g] && (tagQ[g] == lookupTag);
  end

  always_comb begin
    hitData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitData = hitData | dataQ[i];
    end
  end

  assign hit      = |matchVec;
  assign validVec = validQ;
endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int PA_W        = 40,
  parameter int PSC_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   flush,
  input  dpStrobe_t              strobe,
  input  logic [VA_W-1:0]        reqVaddr,
  input  logic                   reqWrite,
  input  logic [PA_W-OFS_W-1:0]  rootFrame,
  input  logic [PTE_W-1:0]       memRdata,
  output logic [PA_W-1:0]        memAddr,
  output logic [PTE_W-1:0]       memWdata,
  output logic [1:0]             level,
  output logic                   entryPresent,
  output logic                   entryLarge,
  output logic                   needUpdate,
  output logic [PA_W-1:0]        rspPaddr,
  output logic [PSC_ENTRIES-1:0] pscValid
);
  localparam int FRAME_W = PA_W - OFS_W;
  localparam int TAG_W   = VA_W - PDE_SHIFT;

  logic [VA_W-1:0]    vaQ;
  logic               wrQ;
  logic [1:0]         lvlQ;
  logic [FRAME_W-1:0] baseQ;
  logic [PTE_W-1:0]   entryQ;
  logic               pscHit;
  logic [FRAME_W-1:0] pscFrame;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] entryFrame;

  pt_walker_psc #(
    .ENTRIES(PSC_ENTRIES), .TAG_W(TAG_W), .DATA_W(FRAME_W)
  ) i_psc (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .lookupTag(reqVaddr[VA_W-1:PDE_SHIFT]),
    .hit      (pscHit),
    .hitData  (pscFrame),
    .fillEn   (strobe.pscFill),
    .fillTag  (vaQ[VA_W-1:PDE_SHIFT]),
    .fillData (entryFrame),
    .validVec (pscValid)
  );

  assign entryFrame = entryQ[PA_W-1:OFS_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      wrQ    <= 1'b0;
      lvlQ   <= 2'd3;
      baseQ  <= '0;
      entryQ <= '0;
    end else begin
      if (strobe.acceptReq) begin
        vaQ   <= reqVaddr;
        wrQ   <= reqWrite;
        lvlQ  <= pscHit ? 2'd0 : 2'd3;
        baseQ <= pscHit ? pscFrame : rootFrame;
      end else if (strobe.stepDown) begin
        lvlQ  <= lvlQ - 2'd1;
        baseQ <= entryFrame;
      end
      if (strobe.latchEntry) entryQ <= memRdata;
    end
  end

  always_comb begin
    unique case (lvlQ)
      2'd3:    idx = vaQ[47:39];
      2'd2:    idx = vaQ[38:30];
      2'd1:    idx = vaQ[29:21];
      default: idx = vaQ[20:12];
    endcase
  end

  assign memAddr = {baseQ, idx, 3'b000};

  always_comb begin
    memWdata = entryQ;
    memWdata[BIT_ACCESSED] = 1'b1;
    if (wrQ) memWdata[BIT_DIRTY] = 1'b1;
  end

  assign needUpdate   = !entryQ[BIT_ACCESSED] || (wrQ && !entryQ[BIT_DIRTY]);
  assign entryPresent = entryQ[BIT_PRESENT];
  assign entryLarge   = entryQ[BIT_LARGE];
  assign level        = lvlQ;

  always_comb begin
    unique case (lvlQ)
      2'd0:    rspPaddr = {entryQ[PA_W-1:OFS_W], vaQ[OFS_W-1:0]};
      2'd1:    rspPaddr = {entryQ[PA_W-1:PDE_SHIFT], vaQ[PDE_SHIFT-1:0]};
      default: rspPaddr = {entryQ[PA_W-1:GIG_SHIFT], vaQ[GIG_SHIFT-1:0]};
    endcase
  end
endmodule

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      rspValid,
  input  logic      rspReady,
  output logic      rspFault,
  output logic      memValid,
  input  logic      memReady,
  output logic      memWrite,
  input  logic      memRdValid,
  input  logic [1:0] level,
  input  logic      entryPresent,
  input  logic      entryLarge,
  input  logic      needUpdate,
  output dpStrobe_t strobe
);
  walkState_t stateQ, stateD;
  logic faultQ, faultD;
  logic isLeaf;

  assign isLeaf = (level == 2'd0) ||
                  (entryLarge && (level == 2'd1 || level == 2'd2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      faultQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      faultQ <= faultD;
    end
  end

  always_comb begin
    stateD   = stateQ;
    faultD   = faultQ;
    strobe   = '0;
    reqReady = 1'b0;
    rspValid = 1'b0;
    memValid = 1'b0;
    memWrite = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.acceptReq = 1'b1;
          stateD = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        memValid = 1'b1;
        if (memReady) stateD = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (memRdValid) begin
          strobe.latchEntry = 1'b1;
          stateD = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (!entryPresent) begin
          faultD = 1'b1;
          stateD = ST_RESP;
        end else if (isLeaf) begin
          faultD = 1'b0;
          stateD = needUpdate ? ST_WR_REQ : ST_RESP;
        end else begin
          strobe.stepDown = 1'b1;
          strobe.pscFill  = (level == 2'd1);
          stateD = ST_RD_REQ;
        end
      end
      ST_WR_REQ: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) stateD = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign rspFault = faultQ;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int PA_W        = 40,
  parameter int PSC_ENTRIES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic [PA_W-13:0]      rootFrame,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [47:0]           reqVaddr,
  input  logic                  reqWrite,
  output logic                  rspValid,
  input  logic                  rspReady,
  output logic                  rspFault,
  output logic [1:0]            rspSize,
  output logic [PA_W-1:0]       rspPaddr,
  output logic                  memValid,
  input  logic                  memReady,
  output logic                  memWrite,
  output logic [PA_W-1:0]       memAddr,
  output logic [63:0]           memWdata,
  input  logic                  memRdValid,
  input  logic [63:0]           memRdata
);
  dpStrobe_t              strobe;
  logic [1:0]             level;
  logic                   entryPresent;
  logic                   entryLarge;
  logic                   needUpdate;
  logic [PSC_ENTRIES-1:0] pscValidVec;

  pt_walker_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .rspFault    (rspFault),
    .memValid    (memValid),
    .memReady    (memReady),
    .memWrite    (memWrite),
    .memRdValid  (memRdValid),
    .level       (level),
    .entryPresent(entryPresent),
    .entryLarge  (entryLarge),
    .needUpdate  (needUpdate),
    .strobe      (strobe)
  );

  pt_walker_dp #(.PA_W(PA_W), .PSC_ENTRIES(PSC_ENTRIES)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .strobe      (strobe),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .rootFrame   (rootFrame),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .level       (level),
    .entryPresent(entryPresent),
    .entryLarge  (entryLarge),
    .needUpdate  (needUpdate),
    .rspPaddr    (rspPaddr),
    .pscValid    (pscValidVec)
  );

  assign rspSize = level;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W        = 40,
  parameter int PSC_ENTRIES = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   flush,
  input logic                   reqReady,
  input logic                   rspValid,
  input logic                   rspReady,
  input logic                   rspFault,
  input logic [1:0]             rspSize,
  input logic [PA_W-1:0]        rspPaddr,
  input logic                   memValid,
  input logic                   memReady,
  input logic                   memWrite,
  input logic [PA_W-1:0]        memAddr,
  input logic [63:0]            memWdata,
  input logic [PSC_ENTRIES-1:0] pscValid
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspPaddr) && $stable(rspFault) && $stable(rspSize)); // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R9

  AST_NO_MEM_DURING_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memValid); // R9

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)); // R10

  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memWrite |-> memWdata[5] && memWdata[0]); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> pscValid == '0); // R8
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .PSC_ENTRIES(PSC_ENTRIES)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .flush   (flush),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .rspReady(rspReady),
  .rspFault(rspFault),
  .rspSize (rspSize),
  .rspPaddr(rspPaddr),
  .memValid(memValid),
  .memReady(memReady),
  .memWrite(memWrite),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .pscValid(pscValidVec)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int PA_W = 40;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            flush = 1'b0;
  logic [PA_W-13:0] rootFrame = 28'h1;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [47:0]     reqVaddr = '0;
  logic            reqWrite = 1'b0;
  logic            rspValid;
  logic            rspReady = 1'b1;
  logic            rspFault;
  logic [1:0]      rspSize;
  logic [PA_W-1:0] rspPaddr;
  logic            memValid;
  logic            memReady;
  logic            memWrite;
  logic [PA_W-1:0] memAddr;
  logic [63:0]     memWdata;
  logic            memRdValid = 1'b0;
  logic [63:0]     memRdata = '0;

  always #4 clk = ~clk; // 125 MHz

  pt_walker #(.PA_W(PA_W), .PSC_ENTRIES(8)) i_pt_walker (.*);

  // memory model
  logic [63:0] pmem [logic [PA_W-1:0]];
  int memStall = 0;
  int stallCnt = 0;
  int readCnt = 0;
  int writeCnt = 0;
  assign memReady = (stallCnt >= memStall);

  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (!rstN) stallCnt <= 0;
    else if (memValid && memReady) begin
      stallCnt <= 0;
      if (memWrite) begin
        pmem[memAddr] = memWdata;
        writeCnt <= writeCnt + 1;
      end else begin
        memRdValid <= 1'b1;
        memRdata <= pmem.exists(memAddr) ? pmem[memAddr] : 64'h0;
        readCnt <= readCnt + 1;
      end
    end else if (memValid) stallCnt <= stallCnt + 1;
    else stallCnt <= 0;
  end

  int nChecks = 0;
  int nFails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] vaOf(input int i3, input int i2, input int i1, input int i0, input int off);
    return (48'(i3) << 39) | (48'(i2) << 30) | (48'(i1) << 21) | (48'(i0) << 12) | 48'(off);
  endfunction

  logic [PA_W-1:0] gotPa;
  logic            gotFlt;
  logic [1:0]      gotSz;
  int              gotRd, gotWr;

  task automatic doWalk(input logic [47:0] va, input logic wr);
    int rd0, wr0;
    rd0 = readCnt; wr0 = writeCnt;
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqValid = 1'b1; rspReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    gotPa = rspPaddr; gotFlt = rspFault; gotSz = rspSize;
    gotRd = readCnt - rd0; gotWr = writeCnt - wr0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [47:0]     va;
    logic            wr;
    logic [PA_W-1:0] pa;
    logic            flt;
    logic [1:0]      sz;
    logic [3:0]      rd;
    logic [3:0]      wb;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{48'h0080_8060_4567, 1'b0, 40'h000ABCD567, 1'b0, 2'd0, 4'd4, 4'd1}, // R1 R5 full walk
    '{48'h0080_8060_4567, 1'b1, 40'h000ABCD567, 1'b0, 2'd0, 4'd1, 4'd1}, // R2 R6 hit + dirty
    '{48'h0080_8060_4567, 1'b0, 40'h000ABCD567, 1'b0, 2'd0, 4'd1, 4'd0}, // R2 R5 no write
    '{48'h0080_80A0_7123, 1'b0, 40'h0000607123, 1'b0, 2'd1, 4'd3, 4'd0}, // R3 2 MiB
    '{48'h0081_8123_4567, 1'b1, 40'h0081234567, 1'b0, 2'd2, 4'd2, 4'd0}, // R3 1 GiB
    '{48'h0100_0000_0000, 1'b0, 40'h0,          1'b1, 2'd3, 4'd1, 4'd0}, // R4 root fault
    '{48'h0080_8060_9000, 1'b0, 40'h0,          1'b1, 2'd0, 4'd1, 4'd0}, // R4 leaf fault
    '{48'h0080_80E0_0000, 1'b0, 40'h0,          1'b1, 2'd1, 4'd3, 4'd0}  // R4 level-1 fault
  };

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        nFails++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [PA_W-1:0] holdPa;
    int rdBase;
    // page tables
    pmem[40'h1008] = 64'h2001;
    pmem[40'h2010] = 64'h3001;
    pmem[40'h3018] = 64'h4001;
    pmem[40'h4020] = 64'hABCD001;
    pmem[40'h3028] = 64'h6000A1;
    pmem[40'h2030] = 64'h800000E1;
    pmem[40'h5000] = 64'h7021;
    for (int k = 10; k <= 18; k++) pmem[40'h3000 + 40'(k * 8)] = 64'h5001;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 reqReady", 64'(reqReady), 64'd1);
    chk("R11 rspValid", 64'(rspValid), 64'd0);
    chk("R11 memValid", 64'(memValid), 64'd0);

    for (int v = 0; v < 8; v++) begin
      memStall = v % 3;
      doWalk(VECS[v].va, VECS[v].wr);
      chk("R4 fault", 64'(gotFlt), 64'(VECS[v].flt));
      chk("R3 size", 64'(gotSz), 64'(VECS[v].sz));
      if (!VECS[v].flt) chk("R1 R3 paddr", 64'(gotPa), 64'(VECS[v].pa));
      chk("R1 R2 R4 reads", 64'(gotRd), 64'(VECS[v].rd));
      chk("R5 R6 writes", 64'(gotWr), 64'(VECS[v].wb));
    end
    memStall = 0;
    chk("R5 R6 leaf flags", pmem[40'h4020], 64'hABCD061);

    // R7 round-robin: 9 fills starting at slot 1
    for (int k = 10; k <= 18; k++) begin
      doWalk(vaOf(1, 2, k, 0, 0), 1'b0);
      chk("R7 miss reads", 64'(gotRd), 64'd4);
      chk("R7 paddr", 64'(gotPa), 64'h7000);
    end
    doWalk(vaOf(1, 2, 11, 0, 0), 1'b0);
    chk("R7 retained", 64'(gotRd), 64'd1);
    doWalk(48'h0080_8060_4567, 1'b0);
    chk("R7 oldest evicted", 64'(gotRd), 64'd4);
    doWalk(vaOf(1, 2, 10, 0, 0), 1'b0);
    chk("R7 second evicted", 64'(gotRd), 64'd4);

    // R8 flush while idle
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    doWalk(vaOf(1, 2, 12, 0, 0), 1'b0);
    chk("R8 after idle flush", 64'(gotRd), 64'd4);

    // R8 flush mid-walk
    rdBase = readCnt;
    fork
      doWalk(vaOf(1, 2, 13, 0, 5), 1'b0);
      begin
        wait (readCnt == rdBase + 1);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
      end
    join
    chk("R8 walk completes", 64'(gotPa), 64'h7005);
    chk("R8 walk reads", 64'(gotRd), 64'd4);
    doWalk(vaOf(1, 2, 13, 0, 0), 1'b0);
    chk("R8 fill after flush", 64'(gotRd), 64'd1);
    doWalk(vaOf(1, 2, 12, 0, 0), 1'b0);
    chk("R8 flushed entry", 64'(gotRd), 64'd4);

    // R9 held response, second request waiting
    @(negedge clk);
    reqVaddr = vaOf(1, 2, 14, 0, 8); reqWrite = 1'b0; reqValid = 1'b1; rspReady = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    holdPa = rspPaddr;
    chk("R9 paddr", 64'(holdPa), 64'h7008);
    reqVaddr = vaOf(1, 2, 15, 0, 0); reqValid = 1'b1;
    rdBase = readCnt;
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk("R9 rsp held", 64'(rspValid), 64'd1);
      chk("R9 busy", 64'(reqReady), 64'd0);
      chk("R9 stable", 64'(rspPaddr), 64'(holdPa));
    end
    chk("R9 no new reads", 64'(readCnt - rdBase), 64'd0);
    reqValid = 1'b0; rspReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle again", 64'(reqReady), 64'd1);

    // R10 slow memory
    memStall = 4;
    doWalk(vaOf(1, 2, 16, 0, 3), 1'b0);
    chk("R10 slow paddr", 64'(gotPa), 64'h7003);
    memStall = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule